// File: doc/BRIEF.md
# Mixed-Signal Self-Test Sequencer

This block drives one self-test pass over an analog path that sits between a DAC and an ADC. Once started, it holds the pattern generator on its test source, lets the analog path settle for a programmed number of cycles with the response accumulator held off, and then opens a measurement window of a second programmed length with the accumulator enabled. When the window closes, it raises a completion flag and keeps it raised until the next start. During a pass the block needs nothing but its clock.

The settle length, the measurement length, the analog loopback route and a small test-mode field are written over a plain address/data write bus. The loopback route drives the analog loopback multiplexers. A host can repeat the pass with a different route each time, and the set of pass/fail outcomes then shows which analog section is faulty. Configuration is frozen while a pass is in flight. For integration, the settle and measure counter widths together should not exceed the accumulator half-width, and the route field should be at least two bits narrower than that half-width.

Top module: `bist_seq_ctrl`

## Requirements
- R1: After a synchronous reset, tpg_bist_sel, ora_clear, ora_enable, init_done, done, lpbk_sel and test_mode are all 0. Both programmed lengths reset to all ones.
- R2: A write to address 0 with data bit 0 set, made while the block is idle, moves it into the settle phase. On the next cycle tpg_bist_sel goes high, ora_clear goes high for exactly one cycle, and ora_enable stays low.
- R3: With settle length L (address 1, low ICNT_W data bits), the settle phase lasts L+1 cycles. In the cycle after it ends, ora_enable and init_done both rise together.
- R4: With measure length M (address 2, low BCNT_W data bits), ora_enable is high for exactly M+1 cycles. In the cycle after that, done rises and both tpg_bist_sel and ora_enable fall.
- R5: ora_enable is never high unless tpg_bist_sel is also high, and it is never high during the settle phase.
- R6: A start write received during the settle or measurement phase is ignored. It produces no ora_clear pulse and does not restart either phase.
- R7: A start write received after done is set begins a new pass. On the next cycle done and init_done are 0 and tpg_bist_sel is 1.
- R8: Writes to addresses 1, 2 and 3 received during the settle or measurement phase are ignored. lpbk_sel, test_mode and both lengths keep their values.
- R9: A write to address 3 while the block is not in a pass loads lpbk_sel from data bits [LPBK_W-1:0] and test_mode from the next MODE_W bits. Both outputs show the new values one cycle after the write.
- R10: A length of 0 gives a phase exactly one cycle long, and a counter held at zero never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 settle length, 2 measure length, 3 route/mode) |
| wr_data | input | DATA_W | Write data |
| tpg_bist_sel | output | 1 | Pattern generator uses its test source |
| ora_clear | output | 1 | One-cycle accumulator clear |
| ora_enable | output | 1 | Accumulator enable |
| init_done | output | 1 | Settle phase has finished |
| done | output | 1 | Whole pass has finished |
| lpbk_sel | output | LPBK_W | Analog loopback route select |
| test_mode | output | MODE_W | Test-mode field |

## Verification
Every output is registered, so a write to any address becomes visible one cycle after the edge that samples it. For example, ora_clear and tpg_bist_sel respond in the cycle after a start. The phase lengths are L+1 and M+1 cycles, counted from that first cycle. The bench keeps a behavioural model that advances on the same edge as the design. It compares every output at the falling edge after each rising edge, so each result is checked in the cycle it is due. Running counts of tpg_bist_sel and ora_enable cycles taken up to the rise of done check the settle and measure durations as whole spans.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  localparam logic [ADDR_W-1:0] REG_CTRL    = 2'd0;
  localparam logic [ADDR_W-1:0] REG_SETTLE  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_MEASURE = 2'd2;
  localparam logic [ADDR_W-1:0] REG_ROUTE   = 2'd3;
endpackage

// File: rtl/bist_down_cnt.sv
module bist_down_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         tc
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (dec && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign tc = (cnt == '0);

  // R10: a counter at zero stays there
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (!load && dec && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/bist_cfg_regs.sv
module bist_cfg_regs
  import bist_seq_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int ICNT_W = 6,
  parameter int BCNT_W = 6,
  parameter int LPBK_W = 3,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              start_req,
  output logic [ICNT_W-1:0] settle_len,
  output logic [BCNT_W-1:0] measure_len,
  output logic [LPBK_W-1:0] lpbk_sel,
  output logic [MODE_W-1:0] test_mode
);
  localparam int ROUTE_W = LPBK_W + MODE_W;

  assign start_req = wr_en && (wr_addr == REG_CTRL) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_len  <= '1;
      measure_len <= '1;
      lpbk_sel    <= '0;
      test_mode   <= '0;
    end else if (wr_en && !busy) begin
      case (wr_addr)
        REG_SETTLE:  settle_len  <= wr_data[ICNT_W-1:0];
        REG_MEASURE: measure_len <= wr_data[BCNT_W-1:0];
        REG_ROUTE: begin
          lpbk_sel  <= wr_data[LPBK_W-1:0];
          test_mode <= wr_data[ROUTE_W-1:LPBK_W];
        end
        default: ;
      endcase
    end
  end

  // R8: configuration frozen during a pass
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(lpbk_sel) && $stable(test_mode) &&
              $stable(settle_len) && $stable(measure_len)));
endmodule

// File: rtl/bist_seq_fsm.sv
module bist_seq_fsm
  import bist_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic settle_tc,
  input  logic measure_tc,
  output logic settle_load,
  output logic settle_dec,
  output logic measure_load,
  output logic measure_dec,
  output logic busy,
  output logic tpg_bist_sel,
  output logic ora_clear,
  output logic ora_enable,
  output logic init_done,
  output logic done
);
  seq_state_t state, nxt;
  logic start_ok;

  assign start_ok     = start_req && (state == ST_IDLE || state == ST_DONE);
  assign busy         = (state == ST_INIT) || (state == ST_RUN);
  assign settle_load  = start_ok;
  assign settle_dec   = (state == ST_INIT);
  assign measure_load = (state == ST_INIT) && settle_tc;
  assign measure_dec  = (state == ST_RUN);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE, ST_DONE: if (start_ok) nxt = ST_INIT;
      ST_INIT:          if (settle_tc) nxt = ST_RUN;
      ST_RUN:           if (measure_tc) nxt = ST_DONE;
      default:          nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      tpg_bist_sel <= 1'b0;
      ora_clear    <= 1'b0;
      ora_enable   <= 1'b0;
      init_done    <= 1'b0;
      done         <= 1'b0;
    end else begin
      state        <= nxt;
      tpg_bist_sel <= (nxt == ST_INIT) || (nxt == ST_RUN);
      ora_clear    <= start_ok;
      ora_enable   <= (nxt == ST_RUN);
      init_done    <= (nxt == ST_RUN) || (nxt == ST_DONE);
      done         <= (nxt == ST_DONE);
    end
  end

  // R2: clear is a single-cycle pulse
  assert_clear_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ora_clear |=> !ora_clear);
  // R5: accumulation only while the generator is in test
  assert_en_needs_sel_R5: assert property (@(posedge clk) disable iff (rst)
    ora_enable |-> tpg_bist_sel);
  // R4: completion excludes generator and accumulator activity
  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!tpg_bist_sel && !ora_enable));
  // R6: start ignored mid-measurement
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (start_req && state == ST_RUN && !measure_tc) |=> (state == ST_RUN && !ora_clear));
endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
  import bist_seq_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int ICNT_W = 6,
  parameter int BCNT_W = 6,
  parameter int LPBK_W = 3,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tpg_bist_sel,
  output logic              ora_clear,
  output logic              ora_enable,
  output logic              init_done,
  output logic              done,
  output logic [LPBK_W-1:0] lpbk_sel,
  output logic [MODE_W-1:0] test_mode
);
  logic              start_req, busy;
  logic [ICNT_W-1:0] settle_len;
  logic [BCNT_W-1:0] measure_len;
  logic              settle_load, settle_dec, settle_tc;
  logic              measure_load, measure_dec, measure_tc;

  bist_cfg_regs #(
    .DATA_W(DATA_W), .ICNT_W(ICNT_W), .BCNT_W(BCNT_W),
    .LPBK_W(LPBK_W), .MODE_W(MODE_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .start_req(start_req), .settle_len(settle_len),
    .measure_len(measure_len), .lpbk_sel(lpbk_sel), .test_mode(test_mode)
  );

  bist_down_cnt #(.W(ICNT_W)) u_settle_cnt (
    .clk(clk), .rst(rst), .load(settle_load), .load_val(settle_len),
    .dec(settle_dec), .tc(settle_tc)
  );

  bist_down_cnt #(.W(BCNT_W)) u_measure_cnt (
    .clk(clk), .rst(rst), .load(measure_load), .load_val(measure_len),
    .dec(measure_dec), .tc(measure_tc)
  );

  bist_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start_req(start_req),
    .settle_tc(settle_tc), .measure_tc(measure_tc),
    .settle_load(settle_load), .settle_dec(settle_dec),
    .measure_load(measure_load), .measure_dec(measure_dec),
    .busy(busy), .tpg_bist_sel(tpg_bist_sel), .ora_clear(ora_clear),
    .ora_enable(ora_enable), .init_done(init_done), .done(done)
  );

  // R5: no accumulation before the settle phase has completed
  assert_en_after_settle_R5: assert property (@(posedge clk) disable iff (rst)
    ora_enable |-> init_done);
endmodule

// File: tb/sim_bist_seq_ctrl.sv
`timescale 1ns/1ps
module sim_bist_seq_ctrl;
  localparam int DW = 6, IW = 6, BW = 6, LW = 3, MW = 3;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic tpg_bist_sel, ora_clear, ora_enable, init_done, done;
  logic [LW-1:0] lpbk_sel;
  logic [MW-1:0] test_mode;

  bist_seq_ctrl #(.DATA_W(DW), .ICNT_W(IW), .BCNT_W(BW), .LPBK_W(LW), .MODE_W(MW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tpg_bist_sel(tpg_bist_sel), .ora_clear(ora_clear), .ora_enable(ora_enable),
    .init_done(init_done), .done(done), .lpbk_sel(lpbk_sel), .test_mode(test_mode)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int sel_cnt = 0, en_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 settle, 2 measure, 3 complete
  int m_phase, m_left, m_ilen, m_mlen, m_lp, m_md;
  bit m_clr, m_idn;

  always @(posedge clk) begin : model
    bit st, bsy;
    if (rst) begin
      m_phase = 0; m_left = 0; m_ilen = (1 << IW) - 1; m_mlen = (1 << BW) - 1;
      m_lp = 0; m_md = 0; m_clr = 0; m_idn = 0;
    end else begin
      bsy = (m_phase == 1) || (m_phase == 2);
      st  = wr_en && (wr_addr == 2'd0) && wr_data[0];
      m_clr = 0;
      if (wr_en && !bsy) begin
        if (wr_addr == 2'd1) m_ilen = int'(wr_data);
        if (wr_addr == 2'd2) m_mlen = int'(wr_data);
        if (wr_addr == 2'd3) begin
          m_lp = int'(wr_data) % (1 << LW);
          m_md = int'(wr_data) / (1 << LW);
        end
      end
      case (m_phase)
        0, 3: if (st) begin m_phase = 1; m_left = m_ilen; m_clr = 1; m_idn = 0; end
        1: if (m_left == 0) begin m_phase = 2; m_left = m_mlen; m_idn = 1; end
           else m_left--;
        2: if (m_left == 0) m_phase = 3; else m_left--;
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin : compare
    if (!rst) begin
      chk(ora_clear == m_clr, "R2 ora_clear", ora_clear, m_clr);
      chk(tpg_bist_sel == (m_phase == 1 || m_phase == 2), "R4 tpg_bist_sel",
          tpg_bist_sel, (m_phase == 1 || m_phase == 2));
      chk(ora_enable == (m_phase == 2), "R3 ora_enable", ora_enable, (m_phase == 2));
      chk(init_done == m_idn, "R3 init_done", init_done, m_idn);
      chk(done == (m_phase == 3), "R4 done", done, (m_phase == 3));
      chk(int'(lpbk_sel) == m_lp, "R9 lpbk_sel", lpbk_sel, m_lp);
      chk(int'(test_mode) == m_md, "R9 test_mode", test_mode, m_md);
      chk(!ora_enable || tpg_bist_sel, "R5 enable without select", ora_enable, 0);
      if (tpg_bist_sel) sel_cnt++;
      if (ora_enable) en_cnt++;
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin : watchdog
    #(5.0 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({tpg_bist_sel, ora_clear, ora_enable, init_done, done} == 5'b0, "R1 flags",
        {tpg_bist_sel, ora_clear, ora_enable, init_done, done}, 0);
    chk(lpbk_sel == 0 && test_mode == 0, "R1 route", {test_mode, lpbk_sel}, 0);

    wr(1, 3); wr(2, 5); wr(3, 2 + (1 << LW));
    chk(lpbk_sel == 3'd2, "R9 route load", lpbk_sel, 2);
    chk(test_mode == 3'd1, "R9 mode load", test_mode, 1);

    sel_cnt = 0; en_cnt = 0;
    wr(0, 1);
    chk(ora_clear == 1'b1, "R2 clear on start", ora_clear, 1);
    chk(tpg_bist_sel == 1'b1 && ora_enable == 1'b0, "R2 select on start",
        {tpg_bist_sel, ora_enable}, 2);
    wr(0, 1);
    chk(ora_clear == 1'b0, "R6 start in settle ignored", ora_clear, 0);
    wr(3, 0);
    chk(lpbk_sel == 3'd2, "R8 route write ignored", lpbk_sel, 2);
    wait_done();
    chk(en_cnt == 6, "R4 measure cycles", en_cnt, 6);
    chk(sel_cnt - en_cnt == 4, "R3 settle cycles", sel_cnt - en_cnt, 4);
    chk(lpbk_sel == 3'd2 && init_done, "R8 route kept", lpbk_sel, 2);

    wr(0, 1);
    chk(!done && !init_done && tpg_bist_sel, "R7 restart from done",
        {done, init_done, tpg_bist_sel}, 1);
    wait_done();

    wr(1, 0); wr(2, 0);
    sel_cnt = 0; en_cnt = 0;
    wr(0, 1);
    wait_done();
    chk(en_cnt == 1, "R10 zero measure length", en_cnt, 1);
    chk(sel_cnt == 2, "R10 zero settle length", sel_cnt, 2);
    @(negedge clk);
    chk(done == 1'b1 && ora_enable == 1'b0, "R4 done holds", done, 1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule